// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Engine

This block is the bus-facing half of a serial EEPROM. It watches a two-wire bus (clock and data lines, sampled by a fast system clock), recognises start and stop conditions, decodes the device select byte, loads the byte address and runs the read flows: current-address, random and sequential. The storage array and the page buffer sit outside. The engine presents a read address and takes back a byte. It hands every accepted write byte to the page buffer with its address, and it signals the buffer to commit when the master ends a write with a stop.

The select byte carries a fixed 4-bit type code, three sub-address bits and a direction bit. With a 2^ADDR_W byte array, the lowest ADDR_W-8 sub-address bits are high array address bits. The remaining sub-address bits are compared with the three strap inputs. A write-protect input lets select and address bytes through but refuses every data byte. While the page buffer reports a write cycle in progress, the engine leaves the bus alone completely.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Bytes clocked in before any start are ignored and never acknowledged.
- R2: After a start, the first byte is taken MSB first, with data sampled on clock rising edges. It is acknowledged (data line pulled low during the ninth clock) only if its bits 7..4 equal 1010b. Bit 0 selects read (1) or write (0).
- R3: Select bits 3..1 form the sub-address. With ADDR_W address bits, the lowest ADDR_W-8 of them supply array address bits 8 and up, and only the remaining bits are compared with the matching strap bits (with ADDR_W=9, select bit 1 is A8 and strap bit 0 is ignored). On a mismatch there is no acknowledge, and the engine ignores the bus until the next start.
- R4: After a write select, the next byte is always acknowledged and, joined with the select's high address bits, loads the address counter. Each later data byte is acknowledged and handed out as a one-cycle wr_valid pulse with the address and the byte.
- R5: wr_commit pulses once for a stop that follows the acknowledge slot of a write in which at least one data byte was accepted. A stop after only an address byte gives no pulse.
- R6: During writes, only the low 4 address bits (the page offset) advance after each byte, so a write wraps within its 16-byte page.
- R7: With wp_in high, the select and address bytes are still acknowledged, but every data byte gets no acknowledge and produces no handoff.
- R8: A random read (a write select, an address byte, a repeated start and a read select) returns the byte at the loaded address.
- R9: In reads, the counter advances by one after every byte output and wraps from the last location to address 0.
- R10: A current-address read continues from the counter. The sub-address bits of a read select leave the counter unchanged.
- R11: If the master leaves the data line high in the acknowledge slot after a read byte, the engine releases the line and goes idle until the next start.
- R12: While busy_in is high, the engine never pulls the data line and acknowledges nothing.
- R13: Read bytes are driven MSB first, and each bit changes only after a clock falling edge. The line is released during the master's acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| wp_in | input | 1 | Write protect: 1 refuses data bytes |
| strap_ce | input | 3 | Board straps compared with the select sub-address |
| busy_in | input | 1 | Page buffer write cycle in progress |
| rd_addr | output | ADDR_W | Array read address (the address counter) |
| rd_data | input | 8 | Array byte at rd_addr |
| wr_valid | output | 1 | One-cycle pulse: accepted write byte |
| wr_addr | output | ADDR_W | Array address of the handed byte |
| wr_data | output | 8 | Handed write byte |
| wr_commit | output | 1 | One-cycle pulse: start the page write cycle |

## Verification
A wrong bit counter or phase shows up at the pins within the same byte. The acknowledge moves to the wrong clock, or read bits come out shifted, and the next sampled bit or acknowledge slot reveals it. A corrupted address counter is invisible until the next handoff or read byte, and then it appears as a wrong wr_addr or wrong data. So the bench crosses both the page boundary and the top of the array before comparing. Missing commit pulses or leaked handoffs under write protect are caught by counting pulses against a queue of expected handoffs.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam logic [3:0] LAST_BIT = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        RX_SEL,
        RX_ADDR,
        RX_DATA
    } rx_kind_e;

    typedef struct packed {
        logic scl_hi;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic [3:0] dev_type;
        logic [2:0] sub;
        logic       rd;
    } sel_byte_t;

    // Sub-address bits still compared with straps once hi_bits are address.
    function automatic logic [2:0] ce_mask(int hi_bits);
        return 3'(3'b111 << hi_bits);
    endfunction

    function automatic logic sel_match(sel_byte_t s, logic [2:0] strap,
                                       logic [2:0] mask);
        return (s.dev_type == DEV_TYPE) && (((s.sub ^ strap) & mask) == 3'b000);
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output line_ev_t ev
);
    localparam int PW = SYNC_STAGES + 1;

    logic [PW-1:0] scl_pipe;
    logic [PW-1:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PW-2:0], scl_raw};
            sda_pipe <= {sda_pipe[PW-2:0], sda_raw};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_pipe[PW-2];
    assign scl_prev = scl_pipe[PW-1];
    assign sda_now  = sda_pipe[PW-2];
    assign sda_prev = sda_pipe[PW-1];

    always_comb begin
        ev.scl_hi   = scl_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.sda      = sda_now;
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_seq,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc_seq) begin
            addr <= addr + 1'b1;
        end else if (inc_page) begin
            addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
        end
    end

    AST_PAGE_ROW_KEPT: assert property (@(posedge clk) disable iff (rst)
        (inc_page && !load && !inc_seq) |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]))); // R6

    AST_SEQ_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (inc_seq && !load && (addr == '1)) |=> (addr == '0)); // R9

endmodule

// File: rtl/eep_proto_fsm.sv
module eep_proto_fsm
    import eep_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              wp,
    input  logic              busy,
    input  logic [2:0]        strap,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        rd_data,
    output logic              sda_pull,
    output logic              ld,
    output logic [ADDR_W-1:0] ld_val,
    output logic              inc_seq,
    output logic              inc_page,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int         HI_BITS = ADDR_W - 8;
    localparam logic [2:0] CE_MASK = ce_mask(HI_BITS);

    phase_e     phase;
    phase_e     after_ack;
    rx_kind_e   kind;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] tx_sh;
    logic [2:0] sel_sub;
    logic       wr_pend;
    logic       mst_ack;

    // Byte address joined with the high bits carried by the select byte.
    logic [ADDR_W-1:0] asm_addr;
    for (genvar b = 0; b < ADDR_W; b++) begin : g_asm
        if (b < 8) begin : g_lo
            assign asm_addr[b] = shreg[b];
        end else begin : g_hi
            assign asm_addr[b] = sel_sub[b-8];
        end
    end

    logic sel_ok;
    assign sel_ok = sel_match(sel_byte_t'(shreg), strap, CE_MASK);

    always_ff @(posedge clk) begin
        ld        <= 1'b0;
        inc_seq   <= 1'b0;
        inc_page  <= 1'b0;
        wr_valid  <= 1'b0;
        wr_commit <= 1'b0;
        if (rst) begin
            phase     <= ST_IDLE;
            after_ack <= ST_IDLE;
            kind      <= RX_SEL;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_sh     <= '0;
            sel_sub   <= '0;
            wr_pend   <= 1'b0;
            mst_ack   <= 1'b0;
            sda_pull  <= 1'b0;
            ld_val    <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else if (busy) begin
            phase    <= ST_IDLE;
            sda_pull <= 1'b0;
            wr_pend  <= 1'b0;
        end else if (ev.start) begin
            phase    <= ST_RX;
            kind     <= RX_SEL;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
            wr_pend  <= 1'b0;
        end else if (ev.stop) begin
            // Commit only when the stop follows a data acknowledge slot.
            if (phase == ST_RX && kind == RX_DATA && bit_cnt == 4'd1 && wr_pend) begin
                wr_commit <= 1'b1;
            end
            phase    <= ST_IDLE;
            sda_pull <= 1'b0;
            wr_pend  <= 1'b0;
        end else begin
            case (phase)
                ST_RX: begin
                    if (ev.scl_rise && bit_cnt != LAST_BIT) begin
                        shreg   <= {shreg[6:0], ev.sda};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (ev.scl_fall && bit_cnt == LAST_BIT) begin
                        phase     <= ST_RX_ACK;
                        after_ack <= ST_RX;
                        case (kind)
                            RX_SEL: begin
                                if (sel_ok) begin
                                    sda_pull <= 1'b1;
                                    sel_sub  <= shreg[3:1];
                                    if (shreg[0]) begin
                                        after_ack <= ST_TX;
                                    end else begin
                                        kind <= RX_ADDR;
                                    end
                                end else begin
                                    after_ack <= ST_IDLE;
                                end
                            end
                            RX_ADDR: begin
                                sda_pull <= 1'b1;
                                ld_val   <= asm_addr;
                                ld       <= 1'b1;
                                kind     <= RX_DATA;
                            end
                            default: begin
                                if (!wp) begin
                                    sda_pull <= 1'b1;
                                    wr_valid <= 1'b1;
                                    wr_addr  <= addr;
                                    wr_data  <= shreg;
                                    inc_page <= 1'b1;
                                    wr_pend  <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (after_ack == ST_TX) begin
                            tx_sh    <= rd_data;
                            sda_pull <= ~rd_data[7];
                            inc_seq  <= 1'b1;
                            phase    <= ST_TX;
                        end else begin
                            sda_pull <= 1'b0;
                            phase    <= after_ack;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_pull <= 1'b0;
                            mst_ack  <= 1'b0;
                            phase    <= ST_TX_ACK;
                        end else begin
                            tx_sh    <= {tx_sh[6:0], 1'b0};
                            sda_pull <= ~tx_sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        mst_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (mst_ack) begin
                            tx_sh    <= rd_data;
                            sda_pull <= ~rd_data[7];
                            inc_seq  <= 1'b1;
                            phase    <= ST_TX;
                        end else begin
                            sda_pull <= 1'b0;
                            phase    <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE) |-> !sda_pull); // R11

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        busy |=> !sda_pull); // R12

    AST_NO_PROTECTED_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !$past(wp)); // R7

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(ev.stop)); // R5

    AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull) && !$past(ev.start) && !$past(ev.stop) && !$past(busy))
        |-> !$past(ev.scl_hi)); // R13

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              wp_in,
    input  logic [2:0]        strap_ce,
    input  logic              busy_in,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    line_ev_t          ev;
    logic              ctr_ld;
    logic [ADDR_W-1:0] ctr_ld_val;
    logic              ctr_inc_seq;
    logic              ctr_inc_page;
    logic [ADDR_W-1:0] ctr_addr;

    eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .ev      (ev)
    );

    eep_proto_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .wp        (wp_in),
        .busy      (busy_in),
        .strap     (strap_ce),
        .addr      (ctr_addr),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull),
        .ld        (ctr_ld),
        .ld_val    (ctr_ld_val),
        .inc_seq   (ctr_inc_seq),
        .inc_page  (ctr_inc_page),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

    eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctr_ld),
        .load_val (ctr_ld_val),
        .inc_seq  (ctr_inc_seq),
        .inc_page (ctr_inc_page),
        .addr     (ctr_addr)
    );

    assign rd_addr = ctr_addr;

endmodule

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
    localparam int ADDR_W = 9;
    localparam int MEM    = 1 << ADDR_W;
    localparam int Q      = 8;

    logic clk = 1'b0;
    logic rst;
    logic m_scl, m_sda;
    logic wp, busy;
    logic [2:0] strap;
    logic sda_pull;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic wr_valid, wr_commit;
    logic sda_bus;

    logic [7:0] arr      [MEM];
    logic [7:0] ref_mem  [MEM];
    logic [ADDR_W+7:0] exp_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    int commits  = 0;
    int busy_pulls = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;
    assign rd_data = arr[rd_addr];

    i2c_eeprom_slave dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (m_scl),
        .sda_in    (sda_bus),
        .sda_pull  (sda_pull),
        .wp_in     (wp),
        .strap_ce  (strap),
        .busy_in   (busy),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected handoffs as the design produces them.
    always @(negedge clk) begin
        if (!rst && wr_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R4", "unexpected write handoff", int'({wr_addr, wr_data}), 0);
            end else begin
                logic [ADDR_W+7:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R6", "handoff address/data",
                      int'({wr_addr, wr_data}), int'(e));
            end
            arr[wr_addr] = wr_data;
        end
        if (!rst && wr_commit) commits++;
        if (!rst && busy && sda_pull) busy_pulls++;
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_sda = b;    wait_q();
        m_scl = 1'b1; wait_q();
        s = sda_bus;  wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack, output logic rel);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~mack, s);
        rel = s;
    endtask

    function automatic logic [7:0] sel(input logic a8, input logic rw);
        return 8'hA8 | {6'b0, a8, rw};
    endfunction

    // Write n bytes from addr with values first+i; returns the ack pattern.
    task automatic write_bytes(input int addr, input int n, input logic [7:0] first,
                               output logic a_sel, output logic a_adr, output int n_ack);
        logic a;
        logic [ADDR_W-1:0] ea;
        n_ack = 0;
        bus_start();
        send_byte(sel(addr[8], 1'b0), a_sel);
        send_byte(addr[7:0], a_adr);
        for (int i = 0; i < n; i++) begin
            ea = ADDR_W'((addr & ~15) | ((addr + i) & 15));
            if (!wp) begin
                exp_q.push_back({ea, first + 8'(i)});
                ref_mem[ea] = first + 8'(i);
            end
            send_byte(first + 8'(i), a);
            if (a) n_ack++;
        end
        bus_stop();
    endtask

    task automatic read_seq(input int addr, input int n, input string req);
        logic a, rel;
        logic [7:0] b;
        int ea;
        bus_start();
        send_byte(sel(addr[8], 1'b0), a);
        send_byte(addr[7:0], a);
        bus_start();
        send_byte(sel(addr[8], 1'b1), a);
        check(a == 1'b1, "R8", "read select after repeated start acked", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            ea = (addr + i) % MEM;
            recv_byte(b, i != n - 1, rel);
            check(b == ref_mem[ea], req, "read byte", int'(b), int'(ref_mem[ea]));
        end
        check(rel == 1'b1, "R13", "line released in master ack slot", int'(rel), 1);
        bus_stop();
    endtask

    initial begin
        logic a, a1, rel;
        logic [7:0] b;
        int na;
        for (int i = 0; i < MEM; i++) begin
            arr[i]     = 8'((i * 7 + 3) & 255);
            ref_mem[i] = 8'((i * 7 + 3) & 255);
        end
        m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; busy = 1'b0; strap = 3'b101;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!sda_pull && !wr_valid && !wr_commit, "R1", "idle outputs after reset",
              int'({sda_pull, wr_valid, wr_commit}), 0);

        // R1: a valid select clocked without a start is ignored
        send_byte(sel(1'b0, 1'b0), a);
        check(a == 1'b0, "R1", "select without start", int'(a), 0);

        // R2: wrong type code; R3: idle until next start
        bus_start();
        send_byte(8'hB8, a);
        check(a == 1'b0, "R2", "wrong type code nacked", int'(a), 0);
        send_byte(sel(1'b0, 1'b0), a);
        check(a == 1'b0, "R3", "no response after mismatch until start", int'(a), 0);
        bus_stop();

        // R3: strap mismatch on select bits 3..2
        bus_start();
        send_byte(8'hAC, a);
        check(a == 1'b0, "R3", "strap mismatch nacked", int'(a), 0);
        bus_stop();

        // R3: strap bit 0 is ignored because select bit 1 is A8
        strap = 3'b100;
        bus_start();
        send_byte(sel(1'b1, 1'b0), a);
        check(a == 1'b1, "R3", "A8 position not compared with strap", int'(a), 1);
        bus_stop();
        strap = 3'b101;
        check(commits == 0, "R5", "no commit without data", commits, 0);

        // R4/R5: single byte write
        write_bytes(32'h123, 1, 8'h5A, a, a1, na);
        check(a == 1'b1, "R2", "write select acked", int'(a), 1);
        check(a1 == 1'b1, "R4", "address byte acked", int'(a1), 1);
        check(na == 1, "R4", "data byte acked", na, 1);
        check(commits == 1, "R5", "commit after byte write", commits, 1);

        // R6: page write wrapping inside the row at 0x100
        write_bytes(32'h10D, 5, 8'h11, a, a1, na);
        check(na == 5, "R6", "page write bytes acked", na, 5);
        check(commits == 2, "R5", "commit after page write", commits, 2);

        // R7: write protect
        wp = 1'b1;
        write_bytes(32'h040, 2, 8'h99, a, a1, na);
        check(a == 1'b1, "R7", "select acked under protect", int'(a), 1);
        check(a1 == 1'b1, "R7", "address acked under protect", int'(a1), 1);
        check(na == 0, "R7", "data refused under protect", na, 0);
        check(commits == 2, "R7", "no commit under protect", commits, 2);
        wp = 1'b0;

        // R5: stop after address only
        bus_start();
        send_byte(sel(1'b0, 1'b0), a);
        send_byte(8'h50, a);
        bus_stop();
        check(commits == 2, "R5", "no commit after address-only write", commits, 2);

        // R8: random reads, including protected location and written byte
        read_seq(32'h10E, 1, "R8");
        read_seq(32'h040, 1, "R7");
        read_seq(32'h123, 1, "R4");
        read_seq(32'h100, 2, "R6");

        // R9: sequential read across the top of the array
        read_seq(32'h1FE, 3, "R9");

        // R10: current address read, select A8 bit does not move counter (now 0x001)
        bus_start();
        send_byte(sel(1'b1, 1'b1), a);
        check(a == 1'b1, "R10", "current read select acked", int'(a), 1);
        recv_byte(b, 1'b0, rel);
        check(b == ref_mem[1], "R10", "current address byte", int'(b), int'(ref_mem[1]));
        // R11: after master nack the engine stays off the bus
        recv_byte(b, 1'b0, rel);
        check(b == 8'hFF, "R11", "bus released after master nack", int'(b), 255);
        bus_stop();

        // R12: busy page buffer
        busy = 1'b1;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte(sel(1'b0, 1'b0), a);
        check(a == 1'b0, "R12", "no ack while busy", int'(a), 0);
        bus_stop();
        busy = 1'b0;
        check(busy_pulls == 0, "R12", "line pulled while busy", busy_pulls, 0);
        bus_start();
        send_byte(sel(1'b0, 1'b0), a);
        check(a == 1'b1, "R12", "ack returns after busy", int'(a), 1);
        bus_stop();

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4", "all expected handoffs seen", exp_q.size(), 0);
        check(commits == 2, "R5", "final commit count", commits, 2);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "R1", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule